// File: doc/BRIEF.md
# GPIO Interrupt Status Aggregator

This block gathers the per-pin interrupt status and wake status flags of a GPIO controller into one 64-bit summary word. Each summary bit stands for a group of four neighbouring pins: bit n is set when any of pins 4n to 4n+3 has its interrupt flag or its wake flag raised. With 184 pins, only bits 0 to 45 carry information. Bits 46 to 63 always read as zero. Software reads the summary as two 32-bit words. It then services only the groups whose bits are set.

The block also drives one parent interrupt line towards the system interrupt controller. The line gives a single-cycle pulse when a summary bit is set and the line is armed. After that pulse it stays quiet until software writes the end-of-interrupt (EOI) bit in the master control word. No acknowledge is needed before servicing. An EOI written while groups are still pending fires the line again in the next cycle.

The register port has a 2-bit word address with a write strobe and a combinational read path. Word 0 is the low summary word (bits 31:0). Word 1 is the high summary word (bits 63:32). Word 2 is the master control word, whose bit 0 is the EOI strobe.

Top module: `gpio_irq_aggr`

## Requirements
- R1: One clock edge after the pin flags change, summary bit n equals the OR of the flags of pins 4n to 4n+3, for n from 0 to 45.
- R2: A pin raises its group bit when only its interrupt flag is set, and also when only its wake flag is set.
- R3: A read of word 0 returns summary bits 31:0. A read of word 1 returns summary bits 63:32, with bits 46 to 63 always zero.
- R4: When the line is armed and the registered summary is non-zero, parent_irq goes high after the next edge for exactly one cycle.
- R5: After the line has fired, parent_irq stays low, whatever the pin flags do, until an EOI is written.
- R6: Writing word 2 with bit 0 set while the summary is non-zero drives parent_irq high in the cycle right after the write edge.
- R7: Writing the EOI while the summary is zero re-arms the line without a pulse. A later non-zero summary then fires it as in R4.
- R8: Word 2 and word 3 always read as zero. Writes to words 0 and 1 do not change what they read.
- R9: Reset clears the summary, drops parent_irq and leaves the line armed.
- R10: A write to word 2 with bit 0 clear has no effect on parent_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_irq_sts | input | 184 | Per-pin interrupt status flags |
| pin_wake_sts | input | 184 | Per-pin wake status flags |
| reg_addr | input | 2 | Word address: 0 summary low, 1 summary high, 2 master control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data; bit 0 of word 2 is EOI |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| parent_irq | output | 1 | Parent interrupt pulse |

## Verification
The summary register is updated one edge after the pin flags change. Its words are read combinationally, so the bench drives the flags on a falling edge, lets one rising edge pass and reads at the next falling edge. A parent pulse caused by pin flags appears after the second rising edge, because the summary register and the interrupt register are in series. A pulse caused by an EOI write appears after the write edge itself. The bench samples parent_irq at the falling edges on both sides of each expected pulse, so it catches a pulse that comes one cycle early, one cycle late, or lasts two cycles.

// File: rtl/gpio_aggr_pkg.sv
package gpio_aggr_pkg;
  localparam int unsigned WORD_SUM_LO = 0;
  localparam int unsigned WORD_SUM_HI = 1;
  localparam int unsigned WORD_MASTER = 2;

  // number of summary bits needed to cover a pin count
  function automatic int unsigned group_count(input int unsigned pins, input int unsigned per);
    return (pins + per - 1) / per;
  endfunction

  // summary bit that a given pin feeds
  function automatic int unsigned group_of_pin(input int unsigned pin, input int unsigned per);
    return pin / per;
  endfunction
endpackage

// File: rtl/gpio_sum_reduce.sv
module gpio_sum_reduce
  import gpio_aggr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 184,
  parameter int unsigned GROUP    = 4,
  parameter int unsigned SUM_W    = 64
) (
  input  logic [NUM_PINS-1:0] irq_sts,
  input  logic [NUM_PINS-1:0] wake_sts,
  output logic [SUM_W-1:0]    sum_next
);
  localparam int unsigned NGRP  = group_count(NUM_PINS, GROUP);
  localparam int unsigned PAD_W = NGRP * GROUP;

  logic [PAD_W-1:0] hit_pad;

  always_comb begin
    hit_pad = '0;
    hit_pad[NUM_PINS-1:0] = irq_sts | wake_sts;
  end

  for (genvar g = 0; g < SUM_W; g++) begin : g_bit
    if (g < NGRP) begin : g_live
      assign sum_next[g] = |hit_pad[g*GROUP +: GROUP];
    end else begin : g_dead
      assign sum_next[g] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_parent_arm.sv
module gpio_parent_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic sum_any,
  input  logic eoi_wr,
  output logic parent_irq,
  output logic armed
);
  logic fire;

  assign fire = (armed || eoi_wr) && sum_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parent_irq <= 1'b0;
      armed      <= 1'b1;
    end else begin
      parent_irq <= fire;
      armed      <= fire ? 1'b0 : (armed || eoi_wr);
    end
  end

  // R4: armed line with pending status fires on the next edge
  p_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && sum_any |=> parent_irq);
  // R5: a pulse is one cycle unless an EOI arrives with it
  p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    parent_irq && !eoi_wr |=> !parent_irq);
  // R5: disarmed line without EOI stays low
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !eoi_wr |=> !parent_irq);
  // R6: EOI with pending status refires at once
  p_eoi_refire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && sum_any |=> parent_irq);
  // R7: EOI with nothing pending leaves the line armed
  p_eoi_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && !sum_any |=> armed && !parent_irq);
endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr
  import gpio_aggr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 184,
  parameter int unsigned GROUP    = 4,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned EOI_BIT  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_irq_sts,
  input  logic [NUM_PINS-1:0] pin_wake_sts,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                parent_irq
);
  localparam int unsigned SUM_W = 2 * REG_W;
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(WORD_SUM_LO);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(WORD_SUM_HI);
  localparam logic [ADDR_W-1:0] A_MS = ADDR_W'(WORD_MASTER);

  logic [SUM_W-1:0] sum_next;
  logic [SUM_W-1:0] sum_q;
  logic             sum_any;
  logic             eoi_wr;
  logic             armed;
  logic             unused_wdata;

  gpio_sum_reduce #(
    .NUM_PINS(NUM_PINS), .GROUP(GROUP), .SUM_W(SUM_W)
  ) u_reduce (
    .irq_sts (pin_irq_sts),
    .wake_sts(pin_wake_sts),
    .sum_next(sum_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_next;
  end

  assign sum_any      = |sum_q;
  assign eoi_wr       = reg_wr && (reg_addr == A_MS) && reg_wdata[EOI_BIT];
  assign unused_wdata = ^reg_wdata;

  gpio_parent_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sum_any   (sum_any),
    .eoi_wr    (eoi_wr),
    .parent_irq(parent_irq),
    .armed     (armed)
  );

  always_comb begin
    case (reg_addr)
      A_LO:    reg_rdata = sum_q[REG_W-1:0];
      A_HI:    reg_rdata = sum_q[SUM_W-1:REG_W];
      default: reg_rdata = '0;
    endcase
  end

  // R1: any live group in the reducer shows as pending one edge later
  p_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|sum_next) |=> sum_any);
  // R8: master word never reads back a value
  p_master_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_MS) |-> (reg_rdata == '0));
  // R9: a disarmed line only follows a pulse or stays low
  p_reset_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    parent_irq |-> !armed || eoi_wr || $past(eoi_wr));
endmodule

// File: tb/tb_gpio_irq_aggr.sv
`timescale 1ns/1ps
module tb_gpio_irq_aggr;
  localparam int NP = 184;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] irq_v = '0;
  logic [NP-1:0] wake_v = '0;
  logic [1:0]    addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          pirq;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_irq_aggr dut (
    .clk(clk), .rst_n(rst_n), .pin_irq_sts(irq_v), .pin_wake_sts(wake_v),
    .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata),
    .parent_irq(pirq)
  );

  // {pin[7:0], use_wake, expected low word, expected high word}
  localparam logic [72:0] VECS [0:7] = '{
    {8'd0,   1'b0, 32'h0000_0001, 32'h0000_0000},
    {8'd3,   1'b1, 32'h0000_0001, 32'h0000_0000},
    {8'd4,   1'b0, 32'h0000_0002, 32'h0000_0000},
    {8'd127, 1'b1, 32'h8000_0000, 32'h0000_0000},
    {8'd128, 1'b0, 32'h0000_0000, 32'h0000_0001},
    {8'd183, 1'b1, 32'h0000_0000, 32'h0000_2000},
    {8'd130, 1'b0, 32'h0000_0000, 32'h0000_0001},
    {8'd64,  1'b1, 32'h0001_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr_word(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    step; step;
    // R9: reset state
    rd(2'd0, d); chk("R9 low word after reset", d, 32'h0);
    rd(2'd1, d); chk("R9 high word after reset", d, 32'h0);
    chk("R9 parent_irq in reset", {31'b0, pirq}, 32'h0);
    rst_n = 1'b1;
    step;

    // R1 R2 R3: one pin at a time, via either flag
    for (int i = 0; i < 8; i++) begin
      irq_v = '0; wake_v = '0;
      if (VECS[i][64]) wake_v[VECS[i][72:65]] = 1'b1;
      else             irq_v[VECS[i][72:65]] = 1'b1;
      step;
      rd(2'd0, d); chk($sformatf("R1 R2 R3 vec%0d low", i), d, VECS[i][63:32]);
      rd(2'd1, d); chk($sformatf("R1 R2 R3 vec%0d high", i), d, VECS[i][31:0]);
    end

    // R3: every pin set, upper bits stay zero
    irq_v = '1; wake_v = '0;
    step;
    rd(2'd0, d); chk("R3 all pins low word", d, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R3 all pins high word", d, 32'h0000_3FFF);

    // R8: writes to summary words ignored, words 2 and 3 read zero
    wr_word(2'd0, 32'h0);
    rd(2'd0, d); chk("R8 write to low word ignored", d, 32'hFFFF_FFFF);
    wr_word(2'd1, 32'h0);
    rd(2'd1, d); chk("R8 write to high word ignored", d, 32'h0000_3FFF);
    rd(2'd2, d); chk("R8 master reads zero", d, 32'h0);
    rd(2'd3, d); chk("R8 word 3 reads zero", d, 32'h0);

    // R7: clear everything, EOI with nothing pending re-arms silently
    irq_v = '0;
    step; step;
    wr_word(2'd2, 32'h1);
    chk("R7 no pulse on empty EOI", {31'b0, pirq}, 32'h0);
    step;
    chk("R7 still quiet", {31'b0, pirq}, 32'h0);

    // R4: pin 10 set, pulse after second edge, one cycle long
    irq_v[10] = 1'b1;
    step;
    chk("R4 not yet after one edge", {31'b0, pirq}, 32'h0);
    step;
    chk("R4 pulse after two edges", {31'b0, pirq}, 32'h1);
    step;
    chk("R4 pulse lasts one cycle", {31'b0, pirq}, 32'h0);

    // R5: new status does not refire without EOI
    wake_v[50] = 1'b1;
    step; step; step;
    chk("R5 held off without EOI", {31'b0, pirq}, 32'h0);

    // R10: write to master with bit 0 clear does nothing
    wr_word(2'd2, 32'hFFFF_FFFE);
    chk("R10 EOI bit clear ignored", {31'b0, pirq}, 32'h0);
    step;
    chk("R10 still quiet next cycle", {31'b0, pirq}, 32'h0);

    // R6: EOI with pending status refires next cycle
    wr_word(2'd2, 32'h1);
    chk("R6 refire after EOI", {31'b0, pirq}, 32'h1);
    step;
    chk("R6 refire is one cycle", {31'b0, pirq}, 32'h0);

    // R9: reset mid-run clears and re-arms
    rst_n = 1'b0;
    step;
    rd(2'd0, d); chk("R9 summary cleared by reset", d, 32'h0);
    chk("R9 parent low in reset", {31'b0, pirq}, 32'h0);
    rst_n = 1'b1;
    step;
    chk("R9 no pulse one edge after reset", {31'b0, pirq}, 32'h0);
    step;
    chk("R9 armed after reset fires", {31'b0, pirq}, 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule